// File: doc/BRIEF.md
# Wrapping burst read controller

This block is the device-side read engine of a 32-bit-wide memory. The host presents an address with an address-valid strobe while chip enable is high. When burst mode is on, the block waits a programmable number of clocks and then returns one 32-bit word per clock. The words come from a window of 2, 4 or 8 words aligned to the burst length. The sequence starts at the presented address and wraps inside the window without end, so the same words repeat until a new strobe or a chip-disable stops it. An end-of-burst indicator marks the final word of each pass through the window.

Reads of the configuration register and of the protection word never burst. They return a single word that stays valid for as long as the output enable is held. Until burst mode is enabled, every read is a simplified asynchronous access: the word for the address on the bus appears one clock later. The same array port serves a 64-word secure region. Burst words whose window address lies past that region are flagged invalid.

Top module: `wrap_burst_reader`

## Requirements
- R1: The 7-bit configuration register resets to zero. Bit 0 enables burst mode. Bits 2:1 select the window: 01 gives 2 words, 10 gives 4, 11 gives 8, and 00 also gives 2. Bits 6:3 hold the latency minus 2, and any value above 14 means a latency of 16.
- R2: In burst mode, a strobe in space 0 (main) or space 3 (secure) starts a burst. Word k of the burst is the array word at the wrapped address for k. Its value is driven on dout with dout_oe high in the cycle after the L+k-th rising edge that follows the edge that sampled the strobe.
- R3: The latency L runs from 2 to 16. dout_oe stays low from the strobe edge until the first word appears.
- R4: The wrapped address for word k is the start address with its low bits (window size minus 1) replaced by (start + k) modulo the window size. After the last word of the window the sequence returns to the start address and keeps cycling.
- R5: eob_oe and eob are high exactly on words where k mod the window size equals the window size minus 1. They are low on all other words.
- R6: A strobe in space 1 (config) or space 2 (protection) returns, one cycle later, the zero-extended config register or the prot_bits input. The word holds for as long as oe stays high, with no array read and no eob, even when burst mode is on.
- R7: With burst mode off and chip enable high, the word for the addr and space presented in a cycle appears in the next cycle. No strobe is needed and eob_oe stays low.
- R8: A new strobe while a burst is running abandons that burst and restarts the latency count with the new address.
- R9: Chip enable low forces dout_oe, eob_oe and arr_re low from the next cycle. After chip enable returns, nothing is driven in burst mode until a new strobe.
- R10: In space 3, arr_sec is high, and dinv is high on every word whose array address is 64 or more.
- R11: oe only gates dout_oe, eob_oe and dinv. The burst keeps advancing one word per clock while oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce | input | 1 | Chip enable, active high |
| adv | input | 1 | Address-valid strobe, active high |
| oe | input | 1 | Output enable, active high |
| addr | input | AW | Word address |
| space | input | 2 | Address space: 0 main, 1 config, 2 protection, 3 secure |
| prot_bits | input | DW | Protection word returned on space-2 reads |
| dout | output | DW | Read data |
| dout_oe | output | 1 | Drive enable for dout (low means high impedance) |
| eob | output | 1 | End-of-burst indicator value |
| eob_oe | output | 1 | Drive enable for eob |
| dinv | output | 1 | Current word lies past the secure region |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 7 | Configuration register write data |
| arr_re | output | 1 | Array read request |
| arr_addr | output | AW | Array read address |
| arr_sec | output | 1 | Array read targets the secure region |
| arr_rdata | input | DW | Array read data, valid the cycle after arr_re |

## Verification
A wrong latency count shows up on the first word of a burst. That word appears a cycle early or late at dout_oe, and the fault is visible within 16 clocks of the strobe. A corrupted window offset shows up as a wrong word on the next beat. The indicator then lands on the wrong beat, and both are seen within one pass of at most 8 words. A stale mode or space decision shows up one cycle after the access, as register data where array data was due, as a missing word, or as an indicator during an asynchronous read.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

  typedef enum logic [1:0] {
    SP_MAIN = 2'd0,
    SP_CFG  = 2'd1,
    SP_PROT = 2'd2,
    SP_SEC  = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAT,
    ST_BURST,
    ST_SINGLE
  } state_e;

  localparam int CFG_W = 7;
  localparam int LAT_W = 5;
  localparam int OFS_W = 3;

  // window size minus one, from the length field
  function automatic logic [OFS_W-1:0] len_mask(input logic [1:0] code);
    case (code)
      2'b10:   return 3'd3;
      2'b11:   return 3'd7;
      default: return 3'd1;
    endcase
  endfunction

  // latency in clocks from the stored field, clamped to 16
  function automatic logic [LAT_W-1:0] lat_decode(input logic [3:0] f);
    if (f > 4'd14) return 5'd16;
    return {1'b0, f} + 5'd2;
  endfunction

  // low address bits of beat k inside an aligned window
  function automatic logic [OFS_W-1:0] wrap_low(input logic [OFS_W-1:0] s,
                                                input logic [OFS_W-1:0] k,
                                                input logic [OFS_W-1:0] m);
    return (s & ~m) | ((s + k) & m);
  endfunction

  function automatic logic is_array_space(input logic [1:0] sp);
    return (sp == SP_MAIN) || (sp == SP_SEC);
  endfunction

endpackage

// File: rtl/wbr_cfg_reg.sv
module wbr_cfg_reg
  import wbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic             burst_en,
  output logic [OFS_W-1:0] mask,
  output logic [LAT_W-1:0] lat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= wdata;
  end

  assign burst_en = cfg_q[0];
  assign mask     = len_mask(cfg_q[2:1]);
  assign lat      = lat_decode(cfg_q[6:3]);

endmodule

// File: rtl/wbr_lat_cnt.sv
module wbr_lat_cnt
  import wbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             run,
  input  logic [LAT_W-1:0] lat,
  output logic             done
);

  logic [LAT_W-1:0] cnt;

  assign done = (cnt == lat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (load)           cnt <= LAT_W'(1);
    else if (run && !done)   cnt <= cnt + LAT_W'(1);
  end

endmodule

// File: rtl/wbr_wrap_gen.sv
module wbr_wrap_gen
  import wbr_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [AW-1:0]    start,
  input  logic [OFS_W-1:0] mask,
  output logic [AW-1:0]    cur_addr,
  output logic [AW-1:0]    start_q,
  output logic             at_last
);

  logic [OFS_W-1:0] beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat    <= '0;
      start_q <= '0;
    end else if (load) begin
      beat    <= '0;
      start_q <= start;
    end else if (step) begin
      beat    <= (beat + OFS_W'(1)) & mask;
    end
  end

  assign at_last  = (beat == mask);
  assign cur_addr = {start_q[AW-1:OFS_W], wrap_low(start_q[OFS_W-1:0], beat, mask)};

endmodule

// File: rtl/wrap_burst_reader.sv
module wrap_burst_reader
  import wbr_pkg::*;
#(
  parameter int AW        = 19,
  parameter int DW        = 32,
  parameter int SEC_WORDS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             adv,
  input  logic             oe,
  input  logic [AW-1:0]    addr,
  input  logic [1:0]       space,
  input  logic [DW-1:0]    prot_bits,
  output logic [DW-1:0]    dout,
  output logic             dout_oe,
  output logic             eob,
  output logic             eob_oe,
  output logic             dinv,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             arr_re,
  output logic [AW-1:0]    arr_addr,
  output logic             arr_sec,
  input  logic [DW-1:0]    arr_rdata
);

  localparam logic [AW-1:0] SEC_LIM = AW'(SEC_WORDS);

  // configuration
  logic [CFG_W-1:0] cfg_q;
  logic             burst_en;
  logic [OFS_W-1:0] win_mask;
  logic [LAT_W-1:0] lat;

  wbr_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .cfg_q    (cfg_q),
    .burst_en (burst_en),
    .mask     (win_mask),
    .lat      (lat)
  );

  // control state and named events
  state_e st;
  logic   sec_q;
  logic   burst_start;
  logic   burst_step;
  logic   async_rd;
  logic   lat_done;
  logic   in_single;

  assign burst_start = ce && burst_en && adv;
  assign in_single   = (st == ST_SINGLE);
  assign burst_step  = ce && burst_en && !adv &&
                       ((st == ST_BURST) || ((st == ST_LAT) && lat_done));
  assign async_rd    = ce && !burst_en && is_array_space(space);

  wbr_lat_cnt u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!ce || !burst_en),
    .load  (burst_start),
    .run   (st == ST_LAT),
    .lat   (lat),
    .done  (lat_done)
  );

  logic [AW-1:0] win_addr;
  logic [AW-1:0] win_start;
  logic          at_last;

  wbr_wrap_gen #(.AW(AW)) u_wrap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (burst_start),
    .step     (burst_step),
    .start    (addr),
    .mask     (win_mask),
    .cur_addr (win_addr),
    .start_q  (win_start),
    .at_last  (at_last)
  );

  // register-space word for the space on the bus
  logic [DW-1:0] reg_word;
  assign reg_word = (space == SP_CFG) ? DW'(cfg_q) : prot_bits;

  // output stage
  logic          out_valid;
  logic          out_arr;
  logic          out_last;
  logic          out_dinv;
  logic [DW-1:0] sdat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sec_q     <= 1'b0;
      out_valid <= 1'b0;
      out_arr   <= 1'b1;
      out_last  <= 1'b0;
      out_dinv  <= 1'b0;
      sdat      <= '0;
    end else if (!ce) begin
      st        <= ST_IDLE;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_dinv  <= 1'b0;
    end else if (!burst_en) begin
      st        <= ST_IDLE;
      out_valid <= 1'b1;
      out_arr   <= is_array_space(space);
      sdat      <= reg_word;
      out_last  <= 1'b0;
      out_dinv  <= (space == SP_SEC) && (addr >= SEC_LIM);
    end else if (adv) begin
      out_last <= 1'b0;
      out_dinv <= 1'b0;
      if (is_array_space(space)) begin
        st        <= ST_LAT;
        sec_q     <= (space == SP_SEC);
        out_valid <= 1'b0;
      end else begin
        st        <= ST_SINGLE;
        out_valid <= 1'b1;
        out_arr   <= 1'b0;
        sdat      <= reg_word;
      end
    end else if (burst_step) begin
      st        <= ST_BURST;
      out_valid <= 1'b1;
      out_arr   <= 1'b1;
      out_last  <= at_last;
      out_dinv  <= sec_q && (win_addr >= SEC_LIM);
    end
  end

  // array port
  assign arr_re   = burst_step || async_rd;
  assign arr_addr = burst_step ? win_addr : addr;
  assign arr_sec  = burst_step ? sec_q : (space == SP_SEC);

  // pin drivers
  assign dout_oe = ce && oe && out_valid;
  assign dout    = out_arr ? arr_rdata : sdat;
  assign eob_oe  = dout_oe && out_last;
  assign eob     = eob_oe;
  assign dinv    = dout_oe && out_dinv;

endmodule

// File: rtl/wbr_chk.sv
module wbr_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce,
  input logic          adv,
  input logic [1:0]    space,
  input logic          dout_oe,
  input logic          eob_oe,
  input logic          arr_re,
  input logic          burst_en,
  input logic          burst_step,
  input logic          at_last,
  input logic          in_single,
  input logic [AW-1:0] win_addr,
  input logic [AW-1:0] win_start,
  input logic [2:0]    win_mask
);

  // R4: after the last beat of the window the address is the start again
  a_r4_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_step && at_last) |=> (win_addr == win_start));

  // R2: every burst read stays inside the aligned window of its start
  a_r2_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    burst_step |-> ((win_addr[AW-1:3] == win_start[AW-1:3]) &&
                    ((win_addr[2:0] & ~win_mask) == (win_start[2:0] & ~win_mask))));

  // R3: no word is driven in the cycle right after a burst strobe
  a_r3_quiet_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && adv && burst_en && (space == 2'd0 || space == 2'd3)) |=> !dout_oe);

  // R6: a register-space read never touches the array
  a_r6_single_no_array: assert property (@(posedge clk) disable iff (!rst_n)
    in_single |-> !arr_re);

  // R9: chip enable low silences the pins next cycle
  a_r9_ce_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> (!dout_oe && !eob_oe && (!arr_re || !burst_en)));

  // R7: no indicator once burst mode has been off for a cycle
  a_r7_async_no_eob: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_en && $past(!burst_en)) |-> !eob_oe);

  // R5: the indicator only follows a burst beat
  a_r5_eob_from_beat: assert property (@(posedge clk) disable iff (!rst_n)
    eob_oe |-> $past(burst_step));

endmodule

bind wrap_burst_reader wbr_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_wrap_burst_reader.sv
`timescale 1ns/1ps
module sim_wrap_burst_reader;

  localparam int AW = 19;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0, adv = 1'b0, oe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    space = 2'd0;
  logic [DW-1:0] prot_bits = 32'h0F0F_1234;
  logic [DW-1:0] dout;
  logic          dout_oe, eob, eob_oe, dinv;
  logic          cfg_we = 1'b0;
  logic [6:0]    cfg_wdata = '0;
  logic          arr_re;
  logic [AW-1:0] arr_addr;
  logic          arr_sec;
  logic [DW-1:0] arr_rdata = '0;

  int total = 0;
  int bad   = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  wrap_burst_reader u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .adv(adv), .oe(oe), .addr(addr),
    .space(space), .prot_bits(prot_bits), .dout(dout), .dout_oe(dout_oe),
    .eob(eob), .eob_oe(eob_oe), .dinv(dinv), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .arr_re(arr_re), .arr_addr(arr_addr),
    .arr_sec(arr_sec), .arr_rdata(arr_rdata)
  );

  function automatic logic [DW-1:0] memval(input logic [AW-1:0] a, input bit s);
    return (32'(a) * 32'h9E37_79B1) ^ (s ? 32'hC3C3_0000 : 32'h0000_1234);
  endfunction

  // address of beat k: aligned base plus rotated offset
  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] st, input int k, input int len);
    int off;
    off = int'(st) % len;
    return AW'(int'(st) - off + ((off + k) % len));
  endfunction

  // synchronous array model
  always_ff @(posedge clk) if (arr_re) arr_rdata <= memval(arr_addr, arr_sec);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic cfg_write(input logic [6:0] v);
    @(negedge clk);
    ce = 1'b0; adv = 1'b0; cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // start a burst at the current negedge and check nb beats
  task automatic burst(input logic [AW-1:0] st, input logic [1:0] sp,
                       input int lat, input int len, input int nb, input string qtag);
    ce = 1'b1; oe = 1'b1; adv = 1'b1; addr = st; space = sp;
    @(negedge clk);
    adv = 1'b0; addr = AW'($urandom);
    chk(qtag, {31'b0, dout_oe}, 32'd0);
    repeat (lat - 1) @(negedge clk);
    chk("R3 latency edge", {31'b0, dout_oe}, 32'd0);
    for (int k = 0; k < nb; k++) begin
      logic [AW-1:0] ea;
      bit            sec;
      @(negedge clk);
      ea  = exp_addr(st, k, len);
      sec = (sp == 2'd3);
      chk("R2 beat valid", {31'b0, dout_oe}, 32'd1);
      chk(k < len ? "R2 beat data" : "R4 wrapped data", dout, memval(ea, sec));
      chk("R5 eob", {31'b0, eob_oe}, {31'b0, (k % len) == len - 1});
      chk("R10 dinv", {31'b0, dinv}, {31'b0, sec && (ea >= 64)});
    end
  endtask

  initial begin
    #600000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    report();
  end

  initial begin
    logic [AW-1:0] a_prev;
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R9 reset dout_oe", {31'b0, dout_oe}, 32'd0);
    chk("R9 reset arr_re", {31'b0, arr_re}, 32'd0);
    ce = 1'b1; oe = 1'b1; space = 2'd1;
    @(negedge clk);
    chk("R1 reset cfg", dout, 32'd0);

    // asynchronous mode
    space = 2'd0; addr = AW'($urandom);
    for (int i = 0; i < 8; i++) begin
      a_prev = addr;
      @(negedge clk);
      chk("R7 async data", dout, memval(a_prev, 1'b0));
      chk("R7 async eob", {31'b0, eob_oe}, 32'd0);
      addr = AW'($urandom);
    end

    // directed burst configurations
    cfg_write({4'd0, 2'b00, 1'b1});
    @(negedge clk); burst(19'h00013, 2'd0, 2, 2, 5, "R1 len00");
    cfg_write({4'd3, 2'b10, 1'b1});
    @(negedge clk); burst(19'h01236, 2'd0, 5, 4, 9, "R3 strobe");
    cfg_write({4'd15, 2'b11, 1'b1});
    @(negedge clk); burst(19'h7FFFD, 2'd0, 16, 8, 17, "R1 lat clamp");
    cfg_write({4'd14, 2'b11, 1'b1});
    @(negedge clk); burst(19'h00045, 2'd3, 16, 8, 9, "R10 sec");
    cfg_write({4'd0, 2'b10, 1'b1});
    @(negedge clk); burst(19'h00022, 2'd3, 2, 4, 4, "R10 sec low");

    // constrained random bursts
    for (int it = 0; it < 10; it++) begin
      int code, lf, ln;
      code = 1 + int'($urandom % 3);
      lf   = int'($urandom % 15);
      ln   = 2 << (code - 1);
      cfg_write({lf[3:0], code[1:0], 1'b1});
      @(negedge clk);
      burst(AW'($urandom), ($urandom % 3 == 0) ? 2'd3 : 2'd0, lf + 2, ln, 2 * ln + 1, "R3 strobe");
    end

    // restart during a burst
    cfg_write({4'd2, 2'b10, 1'b1});
    @(negedge clk);
    burst(19'h00101, 2'd0, 4, 4, 2, "R3 strobe");
    @(negedge clk);
    burst(19'h00A0B, 2'd0, 4, 4, 6, "R8 restart quiet");

    // output enable only gates the pins
    cfg_write({4'd1, 2'b11, 1'b1});
    @(negedge clk);
    burst(19'h00333, 2'd0, 3, 8, 1, "R3 strobe");
    oe = 1'b0;
    @(negedge clk);
    chk("R11 oe low", {31'b0, dout_oe}, 32'd0);
    @(negedge clk);
    chk("R11 oe low eob", {31'b0, eob_oe}, 32'd0);
    oe = 1'b1;
    @(negedge clk);
    chk("R11 advance", dout, memval(exp_addr(19'h00333, 3, 8), 1'b0));

    // register-space reads with burst mode on
    cfg_write({4'd5, 2'b01, 1'b1});
    @(negedge clk);
    ce = 1'b1; oe = 1'b1; adv = 1'b1; space = 2'd1;
    @(negedge clk);
    adv = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk("R6 cfg word", dout, {25'b0, 4'd5, 2'b01, 1'b1});
      chk("R6 cfg valid", {31'b0, dout_oe}, 32'd1);
      chk("R6 no eob", {31'b0, eob_oe}, 32'd0);
      chk("R6 no array", {31'b0, arr_re}, 32'd0);
      @(negedge clk);
    end
    prot_bits = $urandom;
    adv = 1'b1; space = 2'd2;
    @(negedge clk);
    adv = 1'b0;
    repeat (3) begin
      chk("R6 prot word", dout, prot_bits);
      @(negedge clk);
    end

    // chip enable low
    burst(19'h00777, 2'd0, 7, 2, 2, "R3 strobe");
    ce = 1'b0;
    @(negedge clk);
    chk("R9 ce low dout", {31'b0, dout_oe}, 32'd0);
    chk("R9 ce low arr", {31'b0, arr_re}, 32'd0);
    ce = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 idle after ce", {31'b0, dout_oe}, 32'd0);
    chk("R9 idle eob", {31'b0, eob_oe}, 32'd0);

    report();
  end

endmodule